// File: doc/BRIEF.md
# Programmable Frame Sync Generator

This block produces the frame synchronization signal of a synchronous serial port and watches that signal line for a chosen edge. It advances only on cycles where a bit-clock enable is high, so one bit time is the span from one enabled cycle to the next. A period value sets how often a new frame starts. At each frame start the block raises a one-bit-time start strobe for the data shifter and shapes its frame sync output according to a waveform select: a positive or negative pulse of programmable length, a level held while the shifter reports data activity, or a toggle.

The edge detector samples the frame sync line, which may be the block's own output looped back through a pad or a signal from a remote device, on each enabled cycle. When the selected edge (rising or falling) appears, a sticky status flag is set. A clear strobe, normally raised by a status read, drops the flag. One instance serves the transmit side and another the receive side, each with its own configuration inputs.

Top module: `frame_sync_gen`

## Requirements
- R1: While reset is high, on every clock the start strobe and the status flag are driven low and the frame sync output is driven to its idle level: high when the waveform select is 1 or 3, low for any other value.
- R2: The start strobe and the frame sync output change only on clock edges where the bit-clock enable is high.
- R3: With a period value of 0, no frame starts and the start strobe stays low. With a nonzero value N, a frame starts every 2*(N+1) bit times, the first one on the first enabled cycle after reset; the start strobe is high for exactly the bit time that follows each frame start.
- R4: Waveform select 2 gives a positive pulse: the output goes high with the start strobe and stays high for the pulse length field plus one bit times (field 0 gives 1 bit time, field 255 gives 256).
- R5: Waveform select 1 gives a negative pulse with the same timing as R4 and the opposite polarity, idling high.
- R6: Waveform select 3 drives the output low, and select 4 drives it high, for each bit time whose enabled cycle sampled the data-activity input high; otherwise the output takes the opposite level.
- R7: Waveform select 5 inverts the output at every frame start and holds it between frame starts.
- R8: Waveform select 0, 6 and 7 drive the output low.
- R9: The edge select picks the edge that sets the status flag: 0 for a rising edge, 1 for a falling edge of the frame sync line, comparing the line's level on one enabled cycle with its level on the previous enabled cycle (or at reset).
- R10: The status flag stays set until the clear strobe is seen on any clock edge; when a detected edge and a clear arrive on the same edge, the flag is set.
- R11: A frame start that arrives while a pulse is still running restarts the pulse length count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | Bit-clock enable, one bit time per high cycle |
| wave_sel | input | 3 | Frame sync waveform select |
| pulse_len | input | 8 | Pulse length minus one, in bit times |
| period | input | 8 | Period divider value, 0 disables frames |
| edge_sel | input | 1 | Edge to detect: 0 rising, 1 falling |
| data_act | input | 1 | Data transfer active, from the shifter |
| fs_line | input | 1 | Observed frame sync line |
| flag_clr | input | 1 | Clear strobe for the status flag |
| fs_out | output | 1 | Frame sync output |
| sof | output | 1 | Start-of-frame strobe for the data shifter |
| sync_flag | output | 1 | Sticky edge-detected status flag |

## Verification
The properties assume that every input is settled before the rising clock edge and that reset is held high on the first edge, so that the registered state has a known value before any check is armed. The stimulus changes all inputs only on the falling edge, asserts reset from time zero, and changes the configuration fields only between test phases while the generator runs, because a mid-run change is legal but makes the timing of the first frame afterwards depend on the counter phase. Within each phase the bit-clock enable, data activity, observed line and clear strobe vary from cycle to cycle at random.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

  typedef enum logic [2:0] {
    FS_NONE      = 3'd0,
    FS_NEG_PULSE = 3'd1,
    FS_POS_PULSE = 3'd2,
    FS_LOW_DATA  = 3'd3,
    FS_HIGH_DATA = 3'd4,
    FS_TOGGLE    = 3'd5
  } fs_wave_e;

  // Level the output rests at outside an active frame
  function automatic logic idle_level(input logic [2:0] sel);
    return (sel == FS_NEG_PULSE) || (sel == FS_LOW_DATA);
  endfunction

endpackage

// File: rtl/fsg_period.sv
module fsg_period #(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [PER_W-1:0] period,
  output logic             start_now,
  output logic             sof_q
);
  localparam int CNT_W = PER_W + 2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  // last bit time of a frame is 2*(N+1)-1 = 2N+1
  assign last      = CNT_W'({period, 1'b1});
  assign start_now = bit_en && (period != '0) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sof_q <= 1'b0;
    end else if (bit_en) begin
      sof_q <= start_now;
      if (period == '0 || cnt >= last)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fsg_pulse.sv
module fsg_pulse #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             start_now,
  input  logic [LEN_W-1:0] pulse_len,
  output logic             pulse_d
);
  logic             pulse_q;
  logic [LEN_W-1:0] left_q;
  logic [LEN_W-1:0] left_d;

  always_comb begin
    pulse_d = pulse_q;
    left_d  = left_q;
    if (start_now) begin
      pulse_d = 1'b1;
      left_d  = pulse_len;
    end else if (pulse_q) begin
      if (left_q == '0)
        pulse_d = 1'b0;
      else
        left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      left_q  <= '0;
    end else if (bit_en) begin
      pulse_q <= pulse_d;
      left_q  <= left_d;
    end
  end
endmodule

// File: rtl/fsg_shape.sv
module fsg_shape
  import fsg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_en,
  input  logic [2:0] wave_sel,
  input  logic       pulse_d,
  input  logic       start_now,
  input  logic       data_act,
  output logic       fs_q
);
  logic fs_d;

  always_comb begin
    case (wave_sel)
      FS_NEG_PULSE: fs_d = ~pulse_d;
      FS_POS_PULSE: fs_d = pulse_d;
      FS_LOW_DATA:  fs_d = ~data_act;
      FS_HIGH_DATA: fs_d = data_act;
      FS_TOGGLE:    fs_d = start_now ? ~fs_q : fs_q;
      default:      fs_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)
      fs_q <= idle_level(wave_sel);
    else if (bit_en)
      fs_q <= fs_d;
  end
endmodule

// File: rtl/fsg_edge.sv
module fsg_edge (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic edge_sel,
  input  logic fs_line,
  input  logic flag_clr,
  output logic flag_q
);
  logic prev_q;
  logic hit;

  assign hit = bit_en && (edge_sel ? (prev_q && !fs_line)
                                   : (!prev_q && fs_line));

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= fs_line;
      flag_q <= 1'b0;
    end else begin
      if (bit_en)
        prev_q <= fs_line;
      if (hit)
        flag_q <= 1'b1;
      else if (flag_clr)
        flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/frame_sync_gen.sv
module frame_sync_gen #(
  parameter int LEN_W = 8,
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic [2:0]       wave_sel,
  input  logic [LEN_W-1:0] pulse_len,
  input  logic [PER_W-1:0] period,
  input  logic             edge_sel,
  input  logic             data_act,
  input  logic             fs_line,
  input  logic             flag_clr,
  output logic             fs_out,
  output logic             sof,
  output logic             sync_flag
);
  logic start_now;
  logic pulse_d;

  fsg_period #(.PER_W(PER_W)) u_period (
    .clk(clk), .rst(rst), .bit_en(bit_en), .period(period),
    .start_now(start_now), .sof_q(sof)
  );

  fsg_pulse #(.LEN_W(LEN_W)) u_pulse (
    .clk(clk), .rst(rst), .bit_en(bit_en), .start_now(start_now),
    .pulse_len(pulse_len), .pulse_d(pulse_d)
  );

  fsg_shape u_shape (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wave_sel(wave_sel),
    .pulse_d(pulse_d), .start_now(start_now), .data_act(data_act),
    .fs_q(fs_out)
  );

  fsg_edge u_edge (
    .clk(clk), .rst(rst), .bit_en(bit_en), .edge_sel(edge_sel),
    .fs_line(fs_line), .flag_clr(flag_clr), .flag_q(sync_flag)
  );
endmodule

// File: rtl/frame_sync_gen_chk.sv
module frame_sync_gen_chk #(
  parameter int LEN_W = 8,
  parameter int PER_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_en,
  input logic [2:0]       wave_sel,
  input logic [LEN_W-1:0] pulse_len,
  input logic [PER_W-1:0] period,
  input logic             edge_sel,
  input logic             data_act,
  input logic             fs_line,
  input logic             flag_clr,
  input logic             fs_out,
  input logic             sof,
  input logic             sync_flag
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!sof && !sync_flag)); // R1

  AST_SOF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(sof)); // R2

  AST_FS_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(fs_out)); // R2

  AST_NO_FRAME_OFF: assert property (@(posedge clk) disable iff (rst)
    (bit_en && period == '0) |=> !sof); // R3

  AST_HIGH_LEVEL: assert property (@(posedge clk) disable iff (rst)
    (bit_en && wave_sel == 3'd4) |=> (fs_out == $past(data_act))); // R6

  AST_NONE_LOW: assert property (@(posedge clk) disable iff (rst)
    (bit_en && wave_sel == 3'd0) |=> !fs_out); // R8

  AST_CLEAR_ACTS: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !bit_en) |=> !sync_flag); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (sync_flag && !flag_clr) |=> sync_flag); // R10
endmodule

bind frame_sync_gen frame_sync_gen_chk #(.LEN_W(LEN_W), .PER_W(PER_W)) u_chk (.*);

// File: tb/frame_sync_gen_bench.sv
module frame_sync_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_en = 1'b0;
  logic [2:0] wave_sel = 3'd1;
  logic [7:0] pulse_len = 8'd0;
  logic [7:0] period = 8'd0;
  logic       edge_sel = 1'b0;
  logic       data_act = 1'b0;
  logic       fs_line = 1'b0;
  logic       flag_clr = 1'b0;
  logic       fs_out, sof, sync_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  bit cmp_on = 1'b0;
  string phase = "R1";

  int en_pct = 100;

  // reference model state
  int m_cnt, m_left, m_pulse, m_fs, m_sof, m_flag, m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_sync_gen u_frame_sync_gen (
    .clk(clk), .rst(rst), .bit_en(bit_en), .wave_sel(wave_sel),
    .pulse_len(pulse_len), .period(period), .edge_sel(edge_sel),
    .data_act(data_act), .fs_line(fs_line), .flag_clr(flag_clr),
    .fs_out(fs_out), .sof(sof), .sync_flag(sync_flag)
  );

  function automatic int idle_of(input int w);
    return (w == 1 || w == 3) ? 1 : 0;
  endfunction

  always @(posedge clk) begin
    int start, e;
    if (rst) begin
      m_cnt = 0; m_left = 0; m_pulse = 0; m_sof = 0; m_flag = 0;
      m_fs = idle_of(wave_sel); m_prev = fs_line;
    end else begin
      e = 0;
      if (bit_en) begin
        start = (period != 0 && m_cnt == 0);
        m_sof = start;
        if (period == 0 || m_cnt >= 2*(period+1)-1) m_cnt = 0;
        else m_cnt = m_cnt + 1;
        if (start) begin m_pulse = 1; m_left = pulse_len; end
        else if (m_pulse == 1) begin
          if (m_left == 0) m_pulse = 0; else m_left = m_left - 1;
        end
        case (wave_sel)
          3'd1: m_fs = 1 - m_pulse;
          3'd2: m_fs = m_pulse;
          3'd3: m_fs = data_act ? 0 : 1;
          3'd4: m_fs = data_act ? 1 : 0;
          3'd5: if (start) m_fs = 1 - m_fs;
          default: m_fs = 0;
        endcase
        e = edge_sel ? (m_prev == 1 && fs_line == 0) : (m_prev == 0 && fs_line == 1);
        m_prev = fs_line;
      end
      if (e) m_flag = 1;
      else if (flag_clr) m_flag = 0;
    end
  end

  function automatic string fs_tag(input logic [2:0] w);
    case (w)
      3'd1: return "R5";
      3'd2: return "R4";
      3'd3, 3'd4: return "R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (phase %s) at %0t: actual %0d expected %0d", req, phase, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check("R3", sof, m_sof);
      check(fs_tag(wave_sel), fs_out, m_fs);
      check("R10", sync_flag, m_flag);
    end
  end

  task automatic run(input int n, input int clr_pct);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_en   = ($urandom % 100) < en_pct;
      data_act = $urandom % 2;
      fs_line  = ($urandom % 4) == 0 ? ~fs_line : fs_line;
      flag_clr = ($urandom % 100) < clr_pct;
    end
  endtask

  task automatic setup(input string tag, input int w, input int len, input int per, input int pct);
    @(negedge clk);
    rst = 1'b1; phase = tag;
    wave_sel = 3'(w); pulse_len = 8'(len); period = 8'(per); en_pct = pct;
    bit_en = 1'b0; flag_clr = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checks++;
    if (sof !== 1'b0 || sync_flag !== 1'b0 || fs_out !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: actual sof=%b flag=%b fs=%b expected 0 0 1", sof, sync_flag, fs_out);
    end
    wave_sel = 3'd4;
    @(negedge clk);
    checks++;
    if (fs_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset idle: actual %b expected 0", fs_out);
    end
    cmp_on = 1'b1;

    setup("R4", 2, 0, 1, 100);    run(60, 5);
    setup("R4", 2, 255, 200, 100); run(900, 2);
    setup("R5", 1, 3, 5, 50);     run(300, 5);
    setup("R11", 2, 20, 3, 100);  run(200, 5);
    setup("R2", 2, 2, 2, 25);     run(400, 5);
    setup("R6", 3, 0, 4, 60);     run(200, 5);
    setup("R6", 4, 0, 0, 60);     run(200, 5);
    setup("R7", 5, 1, 2, 70);     run(300, 5);
    setup("R8", 0, 1, 2, 100);    run(100, 5);
    setup("R8", 6, 1, 2, 100);    run(100, 5);
    setup("R3", 2, 1, 0, 100);    run(150, 5);
    edge_sel = 1'b0;
    setup("R9", 2, 1, 3, 80);     run(400, 10);
    edge_sel = 1'b1;
    setup("R9", 1, 1, 3, 80);     run(400, 10);
    setup("R10", 5, 1, 1, 50);    run(400, 40);

    cmp_on = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule